// File: doc/BRIEF.md
# Two-Source Interrupt Flag Controller

This block collects two interrupt sources for an 8-bit microcontroller core and presents one request to it. The first source is an external pin. The pin is synchronized, then tested for a low level, a falling edge or a rising edge, as a two-bit sense-control input selects. A detected event latches a pending flag. The second source is a timer overflow flag that the timer block holds. This block only qualifies that flag with an enable bit.

Three byte-wide registers sit on a simple register bus with an address, a write strobe, write data and combinational read data. The external enable register holds one live bit, the external pending register holds one live bit, and the timer enable register holds one live bit. A pending source is requested only while its enable bit and the core's global interrupt-enable input are both high. The block drives the vector of the winning source. The external source wins because it has the lower vector. When the core takes the external vector, its acknowledge clears the external flag. Software can also clear that flag by writing a one to its bit.

The pin is sensed from its pad value. Events are therefore seen whether the pin is an input or is driven as an output by the port logic.

Top module: `irq_flag_ctl`

## Requirements
- R1: After reset, all three registers read 0x00, `irq_req` is 0 and `irq_vec` is 0.
- R2: Register addresses are 0x3B for the external enable (bit 6 live), 0x3A for the external pending flag (bit 6 live) and 0x39 for the timer enable (bit 1 live). Every other bit reads zero, and writes to those bits are ignored.
- R3: Sense-control encoding is 2'b10 for falling edge and 2'b11 for rising edge. An edge on `pin_in` that is driven between clock edges shows in the pending flag after the third rising clock edge, and not after the second.
- R4: Sense-control 2'b01 is reserved and never sets the pending flag, whatever the pin does.
- R5: Sense-control 2'b00 is low level: the flag is set again on every cycle the pin stays low. A set and a clear in the same cycle leave the flag set.
- R6: Writing 0x3A with bit 6 equal to one clears the pending flag. Writing it with bit 6 equal to zero leaves the flag unchanged.
- R7: The external request is active only when the pending flag, the enable bit and `glob_ie` are all one. The timer request is active only when `tmr_ovf_flag`, the timer enable bit and `glob_ie` are all one.
- R8: `irq_vec` is 0x001 for the external request and 0x002 for the timer request. The external request wins when both are active. `irq_vec` is 0 and `irq_req` is 0 when neither is active.
- R9: `irq_ack` clears the external flag only when the external vector is being presented. An acknowledge of the timer vector leaves a set, masked external flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | I/O register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 1 | External interrupt pin, pad value |
| sense_mode | input | 2 | Pin sense selection |
| glob_ie | input | 1 | Global interrupt enable from the core |
| tmr_ovf_flag | input | 1 | Overflow flag held by the timer |
| irq_ack | input | 1 | Core accepts the presented vector |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 12 | Vector address of the request |

## Verification
The bound checker watches the gating and ordering on every cycle. It checks that a request never appears without the global enable, that the external vector wins whenever its conditions hold, that the timer vector only appears with its flag and enable, and that the pending flag only rises after a detected event. It also checks that a write-one clear takes effect unless an event collides with it, that a write of zero leaves the flag alone, and that reserved bits read zero. The directed scenarios show what depends on the order of stimulus: the three-edge latency for each edge polarity, the reserved mode, low level winning over a clear, and acknowledge clearing the flag only on its own vector.

// File: rtl/irq_flag_ctl.sv
`timescale 1ns/1ps
module irq_flag_ctl #(
  parameter int          ADDR_W     = 6,
  parameter int          VEC_W      = 12,
  parameter int          EXT_BIT    = 6,
  parameter int          TMR_BIT    = 1,
  parameter logic [5:0]  EMASK_ADDR = 6'h3B,
  parameter logic [5:0]  EFLAG_ADDR = 6'h3A,
  parameter logic [5:0]  TMASK_ADDR = 6'h39
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              pin_in,
  input  logic [1:0]        sense_mode,
  input  logic              glob_ie,
  input  logic              tmr_ovf_flag,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec
);
  localparam logic [VEC_W-1:0] EXT_VEC = VEC_W'(1);
  localparam logic [VEC_W-1:0] TMR_VEC = VEC_W'(2);

  logic sync_a, sync_b, pin_prev;
  logic ext_en, ext_flag, tmr_en;
  logic pin_event, ext_req, tmr_req, ext_take, wr_clear;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_a   <= 1'b1;
      sync_b   <= 1'b1;
      pin_prev <= 1'b1;
    end else begin
      sync_a   <= pin_in;
      sync_b   <= sync_a;
      pin_prev <= sync_b;
    end

  always_comb
    case (sense_mode)
      2'b00:   pin_event = ~sync_b;
      2'b10:   pin_event = pin_prev & ~sync_b;
      2'b11:   pin_event = ~pin_prev & sync_b;
      default: pin_event = 1'b0;
    endcase

  assign ext_req  = ext_flag & ext_en & glob_ie;
  assign tmr_req  = tmr_ovf_flag & tmr_en & glob_ie;
  assign irq_req  = ext_req | tmr_req;
  assign irq_vec  = ext_req ? EXT_VEC : (tmr_req ? TMR_VEC : '0);
  assign ext_take = irq_ack & ext_req;
  assign wr_clear = bus_we && bus_addr == EFLAG_ADDR && bus_wdata[EXT_BIT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ext_en   <= 1'b0;
      tmr_en   <= 1'b0;
      ext_flag <= 1'b0;
    end else begin
      if (bus_we && bus_addr == EMASK_ADDR) ext_en <= bus_wdata[EXT_BIT];
      if (bus_we && bus_addr == TMASK_ADDR) tmr_en <= bus_wdata[TMR_BIT];
      if (pin_event)                    ext_flag <= 1'b1;
      else if (wr_clear || ext_take)    ext_flag <= 1'b0;
    end

  always_comb
    if (bus_addr == EMASK_ADDR)      bus_rdata = 8'({7'b0, ext_en}   << EXT_BIT);
    else if (bus_addr == EFLAG_ADDR) bus_rdata = 8'({7'b0, ext_flag} << EXT_BIT);
    else if (bus_addr == TMASK_ADDR) bus_rdata = 8'({7'b0, tmr_en}   << TMR_BIT);
    else                             bus_rdata = 8'h00;
endmodule

module irq_flag_ctl_chk #(
  parameter int         ADDR_W     = 6,
  parameter int         VEC_W      = 12,
  parameter int         EXT_BIT    = 6,
  parameter int         TMR_BIT    = 1,
  parameter logic [5:0] EMASK_ADDR = 6'h3B,
  parameter logic [5:0] EFLAG_ADDR = 6'h3A,
  parameter logic [5:0] TMASK_ADDR = 6'h39
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              glob_ie,
  input logic              tmr_ovf_flag,
  input logic              irq_ack,
  input logic              irq_req,
  input logic [VEC_W-1:0]  irq_vec,
  input logic              ext_flag,
  input logic              ext_en,
  input logic              tmr_en,
  input logic              pin_event
);
  logic [7:0] emask_live, tmask_live;
  assign emask_live = 8'(1) << EXT_BIT;
  assign tmask_live = 8'(1) << TMR_BIT;

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_addr == EMASK_ADDR || bus_addr == EFLAG_ADDR) |-> (bus_rdata & ~emask_live) == 8'h00)
    and (bus_addr == TMASK_ADDR |-> (bus_rdata & ~tmask_live) == 8'h00));

  assert_flag_needs_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_flag) |-> $past(pin_event));

  assert_write_one_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == EFLAG_ADDR && bus_wdata[EXT_BIT] && !pin_event) |=> !ext_flag);

  assert_write_zero_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == EFLAG_ADDR && !bus_wdata[EXT_BIT] && ext_flag && !irq_ack) |=> ext_flag);

  assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pin_event |=> ext_flag);

  assert_req_needs_gie_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> glob_ie);

  assert_ext_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_flag && ext_en && glob_ie) |-> (irq_req && irq_vec == VEC_W'(1)));

  assert_timer_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_vec == VEC_W'(2)) |-> (tmr_ovf_flag && tmr_en && !(ext_flag && ext_en)));

  assert_timer_ack_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_vec == VEC_W'(2) && ext_flag && !bus_we) |=> ext_flag);
endmodule

bind irq_flag_ctl irq_flag_ctl_chk #(
  .ADDR_W(ADDR_W), .VEC_W(VEC_W), .EXT_BIT(EXT_BIT), .TMR_BIT(TMR_BIT),
  .EMASK_ADDR(EMASK_ADDR), .EFLAG_ADDR(EFLAG_ADDR), .TMASK_ADDR(TMASK_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .glob_ie(glob_ie),
  .tmr_ovf_flag(tmr_ovf_flag), .irq_ack(irq_ack), .irq_req(irq_req),
  .irq_vec(irq_vec), .ext_flag(ext_flag), .ext_en(ext_en), .tmr_en(tmr_en),
  .pin_event(pin_event)
);

// File: tb/test_irq_flag_ctl.sv
`timescale 1ns/1ps
module test_irq_flag_ctl;
  logic clk = 0, rst_n = 0;
  logic [5:0] bus_addr = 0;
  logic bus_we = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic pin_in = 1;
  logic [1:0] sense_mode = 2'b01;
  logic glob_ie = 0, tmr_ovf_flag = 0, irq_ack = 0, irq_req;
  logic [11:0] irq_vec;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  localparam logic [5:0] A_EM = 6'h3B, A_EF = 6'h3A, A_TM = 6'h39;

  always #2 clk = ~clk;

  irq_flag_ctl i_irq_flag_ctl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .sense_mode(sense_mode), .glob_ie(glob_ie), .tmr_ovf_flag(tmr_ovf_flag),
    .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic chk_flag(input string req, input logic exp);
    logic [7:0] d;
    rd(A_EF, d);
    check(req, d, exp ? 8'h40 : 8'h00);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(A_EM, d); check("R1 emask", d, 8'h00);
    rd(A_EF, d); check("R1 eflag", d, 8'h00);
    rd(A_TM, d); check("R1 tmask", d, 8'h00);
    check("R1 req", irq_req, 0);
    check("R1 vec", irq_vec, 0);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(A_EM, 8'hFF); rd(A_EM, d); check("R2 emask live bit", d, 8'h40);
    wr(A_TM, 8'hFF); rd(A_TM, d); check("R2 tmask live bit", d, 8'h02);
    wr(A_EF, 8'hBF); rd(A_EF, d); check("R2 eflag reserved", d, 8'h00);
    wr(A_EM, 8'hBF); rd(A_EM, d); check("R2 emask cleared", d, 8'h00);
    wr(A_TM, 8'hFD); rd(A_TM, d); check("R2 tmask cleared", d, 8'h00);
    rd(6'h3C, d); check("R2 unmapped", d, 8'h00);
  endtask

  task automatic t_falling;
    sense_mode = 2'b10; cyc(3);
    pin_in = 0; cyc(2); chk_flag("R3 falling not after 2 edges", 0);
    cyc(1); chk_flag("R3 falling after 3 edges", 1);
    wr(A_EF, 8'h00); chk_flag("R6 write zero keeps flag", 1);
    wr(A_EF, 8'h40); chk_flag("R6 write one clears flag", 0);
    cyc(3); chk_flag("R3 falling edge is single event", 0);
    pin_in = 1; cyc(4); chk_flag("R3 rising ignored in falling mode", 0);
  endtask

  task automatic t_rising;
    sense_mode = 2'b11; pin_in = 0; cyc(4);
    chk_flag("R3 falling ignored in rising mode", 0);
    pin_in = 1; cyc(2); chk_flag("R3 rising not after 2 edges", 0);
    cyc(1); chk_flag("R3 rising after 3 edges", 1);
    wr(A_EF, 8'h40); chk_flag("R6 clear after rising", 0);
  endtask

  task automatic t_reserved;
    sense_mode = 2'b01;
    pin_in = 0; cyc(5); pin_in = 1; cyc(5); pin_in = 0; cyc(5);
    chk_flag("R4 reserved mode no event", 0);
    pin_in = 1; cyc(4);
    chk_flag("R4 reserved mode stays clear", 0);
  endtask

  task automatic t_level;
    pin_in = 1; sense_mode = 2'b00; cyc(4);
    chk_flag("R5 high pin no level event", 0);
    pin_in = 0; cyc(3); chk_flag("R5 low level sets", 1);
    wr(A_EF, 8'h40); chk_flag("R5 clear loses to level", 1);
    pin_in = 1; cyc(3); wr(A_EF, 8'h40);
    chk_flag("R5 clear once pin high", 0);
    sense_mode = 2'b01; cyc(1);
  endtask

  task automatic set_flag;
    sense_mode = 2'b10; pin_in = 0; cyc(3);
    pin_in = 1; sense_mode = 2'b01; cyc(3);
  endtask

  task automatic t_gate;
    set_flag(); chk_flag("R7 flag set", 1);
    glob_ie = 0; wr(A_EM, 8'h40);
    check("R7 no req without gie", irq_req, 0);
    glob_ie = 1; wr(A_EM, 8'h00); #0.5;
    check("R7 no req without enable", irq_req, 0);
    wr(A_EM, 8'h40); #0.5;
    check("R7 req all conditions", irq_req, 1);
    check("R8 ext vector", irq_vec, 12'h001);
  endtask

  task automatic t_timer;
    tmr_ovf_flag = 1; wr(A_TM, 8'h02); #0.5;
    check("R8 ext wins over timer", irq_vec, 12'h001);
    irq_ack = 1; cyc(1); irq_ack = 0; #0.5;
    chk_flag("R9 ack clears ext flag", 0);
    check("R8 timer vector", irq_vec, 12'h002);
    check("R7 timer req", irq_req, 1);
    set_flag(); wr(A_EM, 8'h00); #0.5;
    check("R8 masked ext gives timer", irq_vec, 12'h002);
    irq_ack = 1; cyc(1); irq_ack = 0;
    chk_flag("R9 timer ack keeps ext flag", 1);
    glob_ie = 0; #0.5;
    check("R7 timer gated by gie", irq_req, 0);
    glob_ie = 1; tmr_ovf_flag = 0; #0.5;
    check("R8 no request vec zero", irq_vec, 0);
    check("R8 no request", irq_req, 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(2); #0.5; t_reset();
    rst_n = 1; cyc(2);
    t_reset();
    t_regs();
    t_falling();
    t_rising();
    t_reserved();
    t_level();
    t_gate();
    t_timer();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule